// File: doc/BRIEF.md
# Reset Generator with Watchdog

This block is a synchronous supervisor that drives an active-low processor reset. It combines three sources of reset: a supply-good flag that arrives already filtered and synchronous, an active-low manual reset request, and a watchdog that expects the software to toggle a pin. A one-clock tick enable paces every timer. Both timeout lengths are parameters counted in ticks, so a tick of one millisecond gives real-time periods and a faster tick shortens them for test.

The core is a three-state machine. `ST_HOLD` keeps reset asserted while the supply flag is low or the filtered manual request is active. `ST_PERIOD` keeps reset asserted while the reset timer counts a full period. `ST_RUN` releases reset and lets the watchdog count. The transitions are: HOLD to PERIOD when the supply is good and there is no manual request; PERIOD to RUN when the last tick of the period arrives; RUN to PERIOD when the watchdog expires; and PERIOD or RUN to HOLD when the supply flag drops or a manual request is seen. Every entry into PERIOD raises a one-cycle marker output, which neighbouring logic can use.

The watchdog input and the manual request each pass through a two-flop synchronizer. The manual request must stay low for a minimum number of clocks before it counts, which rejects short glitches. A separate flag reports that the watchdog pin is floating. While that flag is set, pin edges are ignored and an internal self-service clears the counter at seven eighths of the timeout, so the watchdog never fires.

Top module: `rst_supervisor`

## Requirements
- R1: `proc_rst_n` (active low) is 0 in the clock after `supply_ok` is sampled 0, and stays 0 as long as `supply_ok` is 0 or the filtered manual request is active.
- R2: When the hold condition ends, `proc_rst_n` stays 0 for exactly `RST_TICKS` ticks and then goes to 1. `timeout_start` is 1 for exactly one clock at the start of every reset period.
- R3: If `supply_ok` drops during a reset period, the period's progress is discarded. After the supply returns, a complete `RST_TICKS` period is counted again.
- R4: With reset released and the watchdog pin not floating, `WD_TICKS` ticks without a synchronized edge on `wdog_in` assert reset, and a fresh `RST_TICKS` period follows.
- R5: Any rising or falling edge on the synchronized `wdog_in` clears the watchdog count while the pin is not floating. At most one edge is counted per clock.
- R6: The watchdog count is held at zero while reset is asserted. After release, a full `WD_TICKS` ticks are needed to expire, however many ticks passed while reset was asserted.
- R7: While `wdog_float` is 1, edges on `wdog_in` are ignored and the count is cleared once it reaches `WD_TICKS*7/8` ticks, so no watchdog reset occurs.
- R8: A low on `manual_n` is seen through a two-flop synchronizer. A low lasting fewer than `MR_FILT_CYCLES` synchronized clocks is ignored. A low lasting `MR_FILT_CYCLES` or more starts the hold condition, and releasing it starts a reset period.
- R9: While `arst_n` is 0, `proc_rst_n` is 0 and `timeout_start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous power-on clear, active low |
| tick | input | 1 | One-clock time-base enable that paces both timers |
| supply_ok | input | 1 | Filtered, synchronous flag: supply above the reset threshold |
| manual_n | input | 1 | Manual reset request, active low, asynchronous |
| wdog_in | input | 1 | Watchdog service pin, asynchronous |
| wdog_float | input | 1 | 1 when the watchdog pin is floating or three-stated |
| proc_rst_n | output | 1 | Processor reset, active low |
| timeout_start | output | 1 | One-clock marker for the start of each reset period |

## Verification
The assertions assume that `supply_ok` and `tick` are synchronous to `clk` and that `tick` is a single-clock pulse. They also assume that `wdog_float` changes only while the pin is held steady. The bench drives every input on the falling edge and emits ticks as isolated one-clock pulses. It holds `wdog_in` constant whenever the floating flag changes. The bench also leaves several clocks of settling, with no ticks, after each change on a synchronized input, so that every tick lands in a known machine state.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_PERIOD = 2'd1,
        ST_RUN    = 2'd2
    } sup_state_e;
endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic stage1;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stage1 <= INIT;
            q      <= INIT;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/sup_mr_filter.sv
module sup_mr_filter #(
    parameter int FILT = 8
) (
    input  logic clk,
    input  logic arst_n,
    input  logic mr_n_sync,
    output logic mr_low
);
    localparam int CW = $clog2(FILT + 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)
            low_cnt <= '0;
        else if (mr_n_sync)
            low_cnt <= '0;
        else if (low_cnt != CW'(FILT))
            low_cnt <= low_cnt + 1'b1;
    end

    assign mr_low = (low_cnt == CW'(FILT));

    // R8: a request may only begin after the synchronized input has been low
    assert_mr_needs_low_R8: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(mr_low) |-> $past(!mr_n_sync));
    // R8: a high input ends the request on the next clock
    assert_mr_release_R8: assert property (@(posedge clk) disable iff (!arst_n)
        mr_n_sync |=> !mr_low);
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
    parameter int WD_TICKS = 1600
) (
    input  logic clk,
    input  logic arst_n,
    input  logic tick,
    input  logic wd_sync,
    input  logic floating,
    input  logic hold,
    output logic expire
);
    localparam int SELF_TICKS = (WD_TICKS * 7) / 8;
    localparam int CW         = $clog2(WD_TICKS + 1);

    logic [CW-1:0] cnt;
    logic          wd_prev;
    logic          pin_edge;
    logic          self_srv;
    logic          clr;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) wd_prev <= 1'b0;
        else         wd_prev <= wd_sync;
    end

    assign pin_edge = wd_sync ^ wd_prev;
    assign self_srv = floating && (cnt >= CW'(SELF_TICKS));
    assign clr      = hold || (pin_edge && !floating) || self_srv;
    assign expire   = !clr && tick && (cnt == CW'(WD_TICKS - 1));

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)
            cnt <= '0;
        else if (clr || expire)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    // R6: count frozen at zero while reset is asserted
    assert_frozen_in_reset_R6: assert property (@(posedge clk) disable iff (!arst_n)
        hold |=> (cnt == '0));
    // R4: expiry only while reset is released
    assert_expire_when_running_R4: assert property (@(posedge clk) disable iff (!arst_n)
        expire |-> !hold);
    // R7: floating pin keeps the count within the self-service point
    assert_float_bounded_R7: assert property (@(posedge clk) disable iff (!arst_n)
        (floating && $past(floating)) |-> (cnt <= CW'(SELF_TICKS)));
    // R5: a serviced edge empties the count
    assert_edge_clears_R5: assert property (@(posedge clk) disable iff (!arst_n)
        (pin_edge && !floating) |=> (cnt == '0));
endmodule

// File: rtl/sup_reset_fsm.sv
module sup_reset_fsm
    import sup_pkg::*;
#(
    parameter int RST_TICKS = 200
) (
    input  logic clk,
    input  logic arst_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic mr_low,
    input  logic wd_expire,
    output logic proc_rst_n,
    output logic timeout_start,
    output logic wd_hold
);
    localparam int CW = $clog2(RST_TICKS + 1);

    sup_state_e    state, next;
    logic [CW-1:0] rcnt;
    logic          start_q;

    always_comb begin
        next = state;
        unique case (state)
            ST_HOLD: begin
                if (supply_ok && !mr_low) next = ST_PERIOD;
            end
            ST_PERIOD: begin
                if (!supply_ok || mr_low)                     next = ST_HOLD;
                else if (tick && rcnt == CW'(RST_TICKS - 1)) next = ST_RUN;
            end
            ST_RUN: begin
                if (!supply_ok || mr_low) next = ST_HOLD;
                else if (wd_expire)       next = ST_PERIOD;
            end
            default: next = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state   <= ST_HOLD;
            rcnt    <= '0;
            start_q <= 1'b0;
        end else begin
            state   <= next;
            start_q <= (next == ST_PERIOD) && (state != ST_PERIOD);
            if (state != ST_PERIOD || next != ST_PERIOD)
                rcnt <= '0;
            else if (tick)
                rcnt <= rcnt + 1'b1;
        end
    end

    always_comb begin
        proc_rst_n    = (state == ST_RUN);
        wd_hold       = (state != ST_RUN);
        timeout_start = start_q;
    end

    // R1: supply loss asserts reset in the next clock
    assert_supply_low_R1: assert property (@(posedge clk) disable iff (!arst_n)
        !supply_ok |=> !proc_rst_n);
    // R1: manual request asserts reset in the next clock
    assert_manual_low_R1: assert property (@(posedge clk) disable iff (!arst_n)
        mr_low |=> !proc_rst_n);
    // R2: release only on the last tick of a full period
    assert_full_period_R2: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(proc_rst_n) |-> ($past(tick) && $past(rcnt) == CW'(RST_TICKS - 1)));
    // R2: the start marker is one clock wide and falls inside reset
    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!arst_n)
        timeout_start |-> (!proc_rst_n && !$past(timeout_start)));
    // R3: the period counter is empty whenever the machine is held
    assert_hold_clears_R3: assert property (@(posedge clk) disable iff (!arst_n)
        (state == ST_HOLD) |-> (rcnt == '0));
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int RST_TICKS      = 200,
    parameter int WD_TICKS       = 1600,
    parameter int MR_FILT_CYCLES = 8
) (
    input  logic clk,
    input  logic arst_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic manual_n,
    input  logic wdog_in,
    input  logic wdog_float,
    output logic proc_rst_n,
    output logic timeout_start
);
    logic mr_n_sync;
    logic wd_sync;
    logic mr_low;
    logic wd_expire;
    logic wd_hold;

    sup_sync2 #(.INIT(1'b1)) u_mr_sync (
        .clk(clk), .arst_n(arst_n), .d(manual_n), .q(mr_n_sync)
    );

    sup_sync2 #(.INIT(1'b0)) u_wd_sync (
        .clk(clk), .arst_n(arst_n), .d(wdog_in), .q(wd_sync)
    );

    sup_mr_filter #(.FILT(MR_FILT_CYCLES)) u_mr_filter (
        .clk(clk), .arst_n(arst_n), .mr_n_sync(mr_n_sync), .mr_low(mr_low)
    );

    sup_wdog #(.WD_TICKS(WD_TICKS)) u_wdog (
        .clk(clk), .arst_n(arst_n), .tick(tick), .wd_sync(wd_sync),
        .floating(wdog_float), .hold(wd_hold), .expire(wd_expire)
    );

    sup_reset_fsm #(.RST_TICKS(RST_TICKS)) u_fsm (
        .clk(clk), .arst_n(arst_n), .tick(tick), .supply_ok(supply_ok),
        .mr_low(mr_low), .wd_expire(wd_expire), .proc_rst_n(proc_rst_n),
        .timeout_start(timeout_start), .wd_hold(wd_hold)
    );
endmodule

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int RST_T      = 5;
    localparam int WD_T       = 16;
    localparam int FILT       = 3;

    localparam logic [1:0] OP_TICK = 2'd0;
    localparam logic [1:0] OP_TGL  = 2'd1;
    localparam logic [1:0] OP_FON  = 2'd2;
    localparam logic [1:0] OP_FOFF = 2'd3;

    // {op, count, expected proc_rst_n}
    localparam int NV = 13;
    localparam logic [10:0] VEC [0:NV-1] = '{
        {OP_TICK, 8'd10, 1'b1},  // R6 counting after release
        {OP_TGL,  8'd0,  1'b1},  // R5 rising edge
        {OP_TICK, 8'd15, 1'b1},  // R5 count restarted
        {OP_TICK, 8'd1,  1'b0},  // R4 expiry
        {OP_TICK, 8'd4,  1'b0},  // R4 period in progress
        {OP_TICK, 8'd1,  1'b1},  // R4 full period then release
        {OP_FON,  8'd0,  1'b1},  // R7
        {OP_TICK, 8'd40, 1'b1},  // R7 self-service, no expiry
        {OP_FOFF, 8'd0,  1'b1},  // R7
        {OP_TGL,  8'd0,  1'b1},  // R5 falling edge
        {OP_TICK, 8'd15, 1'b1},  // R5
        {OP_TICK, 8'd1,  1'b0},  // R4
        {OP_TICK, 8'd5,  1'b1}   // R2
    };

    logic clk = 1'b0;
    logic arst_n, tick, supply_ok, manual_n, wdog_in, wdog_float;
    logic proc_rst_n, timeout_start;
    int   n_checks = 0;
    int   n_fail   = 0;
    int   n_starts = 0;
    bit   done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rst_supervisor #(.RST_TICKS(RST_T), .WD_TICKS(WD_T), .MR_FILT_CYCLES(FILT)) dut (
        .clk(clk), .arst_n(arst_n), .tick(tick), .supply_ok(supply_ok),
        .manual_n(manual_n), .wdog_in(wdog_in), .wdog_float(wdog_float),
        .proc_rst_n(proc_rst_n), .timeout_start(timeout_start)
    );

    always @(posedge clk) if (arst_n && timeout_start) n_starts++;

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        arst_n = 1'b0; tick = 1'b0; supply_ok = 1'b0; manual_n = 1'b1;
        wdog_in = 1'b0; wdog_float = 1'b0;
        idle(3);
        check("R9 reset level", proc_rst_n, 1'b0);
        check("R9 start marker", timeout_start, 1'b0);
        arst_n = 1'b1;
        idle(2);
        check("R1 supply low holds reset", proc_rst_n, 1'b0);

        supply_ok = 1'b1;
        idle(1);
        check("R2 start marker high", timeout_start, 1'b1);
        idle(1);
        check("R2 start marker one clock", timeout_start, 1'b0);
        ticks(RST_T - 1);
        check("R2 before last tick", proc_rst_n, 1'b0);
        ticks(1);
        check("R2 released after period", proc_rst_n, 1'b1);

        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i][10:9])
                OP_TICK: ticks(int'(VEC[i][8:1]));
                OP_TGL:  begin wdog_in = ~wdog_in; idle(4); end
                OP_FON:  begin wdog_float = 1'b1; idle(4); end
                OP_FOFF: begin wdog_float = 1'b0; idle(4); end
            endcase
            check($sformatf("R4/R5/R7 vector %0d", i), proc_rst_n, VEC[i][0]);
        end

        // R8 short manual pulse ignored
        manual_n = 1'b0; idle(FILT - 1); manual_n = 1'b1; idle(6);
        check("R8 short pulse ignored", proc_rst_n, 1'b1);
        // R8 long manual pulse
        manual_n = 1'b0; idle(8);
        check("R8 long pulse resets", proc_rst_n, 1'b0);
        ticks(10);
        check("R1 held while manual low", proc_rst_n, 1'b0);
        manual_n = 1'b1; idle(6);
        ticks(RST_T - 1);
        check("R8 period after manual release", proc_rst_n, 1'b0);
        ticks(1);
        check("R8 released", proc_rst_n, 1'b1);

        // R3 supply drop during the period
        supply_ok = 1'b0; idle(2);
        check("R1 supply drop", proc_rst_n, 1'b0);
        ticks(20);
        supply_ok = 1'b1; idle(2);
        ticks(3);
        supply_ok = 1'b0; idle(2);
        supply_ok = 1'b1; idle(2);
        ticks(RST_T - 1);
        check("R3 period restarted", proc_rst_n, 1'b0);
        ticks(1);
        check("R3 full period then release", proc_rst_n, 1'b1);

        // R6 ticks during reset did not advance the watchdog
        ticks(WD_T - 1);
        check("R6 frozen during reset", proc_rst_n, 1'b1);
        ticks(1);
        check("R6 expiry after full window", proc_rst_n, 1'b0);
        idle(3);
        check("R2 one marker per period", logic'(n_starts == 7), 1'b1);

        done = 1'b1;
        finish_run();
    end
endmodule